// File: doc/BRIEF.md
# I2C Slave Register Access Engine

This block is a byte-oriented slave front end for a two-wire serial bus. It gives an external host read and write access to a register file that sits beside it. Both bus lines are oversampled on the system clock. The block finds START, repeated START and STOP conditions. It keeps an internal register pointer and turns each data byte on the bus into a single-cycle write or read strobe toward the register file. The register file itself is outside the block.

A host first sends the device address with the write direction, then one byte that sets the pointer. After that it either streams data bytes to write, or issues a repeated START with the read direction and clocks data out. The pointer advances after every byte. Inside one configurable address window it holds still, so that a FIFO-like or command-port location can be hit repeatedly. The upper four address bits are fixed. The lower three come from strap pins, which are sampled once just after reset and again on general-call re-latch commands. A general-call command can also raise a one-cycle soft-reset request.

Top module: `i2c_reg_slave`

## Requirements
- R1: Before the first START the block ignores all clock and data activity: it never drives SDA and raises no strobe. A START is SDA falling while SCL is high. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: Incoming SDA is taken on SCL rising edges. The block changes its SDA drive only while SCL is low.
- R3: The device answers address byte {4'b1000, A2, A1, A0, rw}. A2..A0 are the strap inputs, sampled once in the first clock after reset is released; later strap changes have no effect until a re-latch. On a match the block pulls SDA low for the ninth clock. On any other address it neither acknowledges nor strobes until the next START.
- R4: After address+W, the first byte loads the pointer. Each following byte gives one regWrEn pulse, with regAddr equal to the pointer and regWrData equal to the byte, during the acknowledge bit. Every such byte is acknowledged.
- R5: The pointer advances by one after each byte written or fetched, and wraps from 0xFF to 0x00.
- R6: While the pointer lies in NOINC_LO..NOINC_HI inclusive (default 0x60..0x63), it does not advance.
- R7: After address+R, one regRdEn pulse fetches regRdData at regAddr during the address acknowledge bit. The byte is sent MSB first. Each master ACK fetches the next byte. A master NACK fetches nothing more, and the block releases the bus.
- R8: A START in any state, including partway through a byte, restarts address reception. An unfinished byte produces no strobe.
- R9: Address byte 0x00 (general call, write) is acknowledged and the next byte is taken as a command. Address byte 0x01 is not acknowledged.
- R10: General-call command 0x06 is acknowledged. It pulses softReset for one cycle, clears the pointer to 0x00 and re-latches the strap bits.
- R11: General-call command 0x04 is acknowledged and re-latches the strap bits; the pointer and softReset are untouched. Any other command value is not acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired-AND bus) |
| strapIn | input | 3 | Strap pins giving the low device address bits |
| sdaDriveLow | output | 1 | High pulls SDA low (open-drain enable) |
| regAddr | output | 8 | Register pointer presented to the register file |
| regWrData | output | 8 | Byte to write |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdEn | output | 1 | One-cycle register read strobe |
| regRdData | input | 8 | Register file read data, valid in the regRdEn cycle |
| softReset | output | 1 | One-cycle soft-reset request from general call 0x06 |

## Verification
The hardest case to reach is a START that lands partway through a byte while the pointer points at an already-written location. Whether the half-received byte is thrown away can only be seen by checking that the register file stays untouched. The bench clocks out three bits of a byte, then issues a fresh START and a full write elsewhere, and then checks both locations. Strap re-latching is also hard to see at the ports. The bench changes the strap pins after reset and then probes old and new device addresses around each general-call command.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  localparam int BYTE_W = 8;

  // Bus events derived from the oversampled lines, one cycle wide.
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaBit;
  } busEvt_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadPtr;
    logic advPtr;
    logic loadTx;
    logic relatch;
    logic clrPtr;
    logic wrStb;
    logic rdStb;
  } dpCmd_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RXACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_WDATA,
    BK_GCCMD
  } byteKind_t;

endpackage

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp
  import i2c_slave_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              STRAP_W     = 3,
  parameter logic [6:0]      DEV_BASE    = 7'h40,
  parameter logic [BYTE_W-1:0] NOINC_LO  = 8'h60,
  parameter logic [BYTE_W-1:0] NOINC_HI  = 8'h63
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic [BYTE_W-1:0]  regRdData,
  input  dpCmd_t             cmd,
  output busEvt_t            evt,
  output logic               sclLvl,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               txMsb,
  output logic               addrHit,
  output logic               gcHit,
  output logic [BYTE_W-1:0]  ptr
);

  localparam int HI_W = 7 - STRAP_W;

  // ---------------- line synchronisers ----------------
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[0] <= 1'b1;
          sdaPipe[0] <= 1'b1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[s] <= 1'b1;
          sdaPipe[s] <= 1'b1;
        end else begin
          sclPipe[s] <= sclPipe[s-1];
          sdaPipe[s] <= sdaPipe[s-1];
        end
      end
    end
  end

  logic sdaLvl;
  logic sclPrev;
  logic sdaPrev;

  assign sclLvl = sclPipe[SYNC_STAGES-1];
  assign sdaLvl = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  always_comb begin
    evt.sclRise = sclLvl & ~sclPrev;
    evt.sclFall = ~sclLvl & sclPrev;
    evt.start   = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
    evt.stop    = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
    evt.sdaBit  = sdaLvl;
  end

  // ---------------- byte registers and pointer ----------------
  logic [BYTE_W-1:0]  txReg;
  logic [STRAP_W-1:0] devLow;
  logic               strapArm;
  logic               inWin;

  assign inWin = (ptr >= NOINC_LO) && (ptr <= NOINC_HI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      txReg    <= '1;
      ptr      <= '0;
      devLow   <= '0;
      strapArm <= 1'b1;
    end else begin
      if (cmd.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaLvl};

      if (cmd.loadTx)        txReg <= regRdData;
      else if (cmd.shiftOut) txReg <= {txReg[BYTE_W-2:0], 1'b1};

      if (cmd.clrPtr)       ptr <= '0;
      else if (cmd.loadPtr) ptr <= rxByte;
      else if (cmd.advPtr)  ptr <= inWin ? ptr : ptr + 1'b1;

      if (strapArm || cmd.relatch) devLow <= strapIn;
      strapArm <= 1'b0;
    end
  end

  assign txMsb   = txReg[BYTE_W-1];
  assign addrHit = (rxByte[BYTE_W-1:1] == {DEV_BASE[6:STRAP_W], devLow});
  assign gcHit   = (rxByte == '0);

  // R6: a pointer inside the window holds when asked to advance
  assert_noinc_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.advPtr && inWin && !cmd.clrPtr && !cmd.loadPtr) |=> (ptr == $past(ptr)));

  // R5: advancing from the top address wraps to zero
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.advPtr && !inWin && !cmd.clrPtr && !cmd.loadPtr && ptr == '1) |=> (ptr == '0));

  logic unusedHi;
  assign unusedHi = (HI_W < 0);

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
#(
  parameter logic [BYTE_W-1:0] GC_RESET_CMD = 8'h06,
  parameter logic [BYTE_W-1:0] GC_LATCH_CMD = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              addrHit,
  input  logic              gcHit,
  input  logic              txMsb,
  output dpCmd_t            cmd,
  output logic              sdaDriveLow,
  output logic              softReset
);

  localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);
  localparam logic [3:0] LAST_TX_BIT   = 4'(BYTE_W - 1);

  phase_t    phase, phaseN;
  phase_t    afterAck, afterAckN;
  byteKind_t kind, kindN;
  logic [3:0] cnt, cntN;
  logic       mAck, mAckN;

  always_comb begin
    cmd       = '0;
    softReset = 1'b0;
    phaseN    = phase;
    afterAckN = afterAck;
    kindN     = kind;
    cntN      = cnt;
    mAckN     = mAck;

    if (evt.start) begin
      phaseN = PH_RX;
      kindN  = BK_ADDR;
      cntN   = '0;
    end else if (evt.stop) begin
      phaseN = PH_IDLE;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (evt.sclRise && cnt < BITS_PER_BYTE) begin
            cmd.shiftIn = 1'b1;
            cntN        = cnt + 4'd1;
          end else if (evt.sclFall && cnt == BITS_PER_BYTE) begin
            cntN   = '0;
            phaseN = PH_RXACK;
            unique case (kind)
              BK_ADDR: begin
                if (addrHit) begin
                  if (rxByte[0]) begin
                    cmd.rdStb  = 1'b1;
                    cmd.loadTx = 1'b1;
                    cmd.advPtr = 1'b1;
                    afterAckN  = PH_TX;
                  end else begin
                    kindN     = BK_PTR;
                    afterAckN = PH_RX;
                  end
                end else if (gcHit) begin
                  kindN     = BK_GCCMD;
                  afterAckN = PH_RX;
                end else begin
                  phaseN = PH_IDLE;
                end
              end
              BK_PTR: begin
                cmd.loadPtr = 1'b1;
                kindN       = BK_WDATA;
                afterAckN   = PH_RX;
              end
              BK_WDATA: begin
                cmd.wrStb  = 1'b1;
                cmd.advPtr = 1'b1;
                afterAckN  = PH_RX;
              end
              BK_GCCMD: begin
                if (rxByte == GC_RESET_CMD) begin
                  softReset   = 1'b1;
                  cmd.relatch = 1'b1;
                  cmd.clrPtr  = 1'b1;
                  afterAckN   = PH_IDLE;
                end else if (rxByte == GC_LATCH_CMD) begin
                  cmd.relatch = 1'b1;
                  afterAckN   = PH_IDLE;
                end else begin
                  phaseN = PH_IDLE;
                end
              end
              default: phaseN = PH_IDLE;
            endcase
          end
        end
        PH_RXACK: begin
          if (evt.sclFall) begin
            phaseN = afterAck;
            cntN   = '0;
          end
        end
        PH_TX: begin
          if (evt.sclFall) begin
            cmd.shiftOut = 1'b1;
            if (cnt == LAST_TX_BIT) begin
              phaseN = PH_TXACK;
              cntN   = '0;
            end else begin
              cntN = cnt + 4'd1;
            end
          end
        end
        PH_TXACK: begin
          if (evt.sclRise) begin
            mAckN = ~evt.sdaBit;
            if (!evt.sdaBit) begin
              cmd.rdStb  = 1'b1;
              cmd.loadTx = 1'b1;
              cmd.advPtr = 1'b1;
            end
          end else if (evt.sclFall) begin
            phaseN = mAck ? PH_TX : PH_IDLE;
            cntN   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      afterAck <= PH_IDLE;
      kind     <= BK_ADDR;
      cnt      <= '0;
      mAck     <= 1'b0;
    end else begin
      phase    <= phaseN;
      afterAck <= afterAckN;
      kind     <= kindN;
      cnt      <= cntN;
      mAck     <= mAckN;
    end
  end

  assign sdaDriveLow = (phase == PH_RXACK) || (phase == PH_TX && !txMsb);

  // R1: a STOP always leaves the data line released
  assert_release_on_stop_R1: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> !sdaDriveLow);

  // R7: write, read and soft-reset strobes never coincide
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.wrStb, cmd.rdStb, softReset}));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slave_pkg::*;
#(
  parameter int                SYNC_STAGES  = 2,
  parameter int                STRAP_W      = 3,
  parameter logic [6:0]        DEV_BASE     = 7'h40,
  parameter logic [BYTE_W-1:0] NOINC_LO     = 8'h60,
  parameter logic [BYTE_W-1:0] NOINC_HI     = 8'h63,
  parameter logic [BYTE_W-1:0] GC_RESET_CMD = 8'h06,
  parameter logic [BYTE_W-1:0] GC_LATCH_CMD = 8'h04
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapIn,
  output logic               sdaDriveLow,
  output logic [BYTE_W-1:0]  regAddr,
  output logic [BYTE_W-1:0]  regWrData,
  output logic               regWrEn,
  output logic               regRdEn,
  input  logic [BYTE_W-1:0]  regRdData,
  output logic               softReset
);

  busEvt_t           evt;
  dpCmd_t            cmd;
  logic              sclLvl;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;
  logic              addrHit;
  logic              gcHit;
  logic [BYTE_W-1:0] ptr;

  i2c_slave_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .STRAP_W    (STRAP_W),
    .DEV_BASE   (DEV_BASE),
    .NOINC_LO   (NOINC_LO),
    .NOINC_HI   (NOINC_HI)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strapIn  (strapIn),
    .regRdData(regRdData),
    .cmd      (cmd),
    .evt      (evt),
    .sclLvl   (sclLvl),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .addrHit  (addrHit),
    .gcHit    (gcHit),
    .ptr      (ptr)
  );

  i2c_slave_ctrl #(
    .GC_RESET_CMD(GC_RESET_CMD),
    .GC_LATCH_CMD(GC_LATCH_CMD)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .rxByte     (rxByte),
    .addrHit    (addrHit),
    .gcHit      (gcHit),
    .txMsb      (txMsb),
    .cmd        (cmd),
    .sdaDriveLow(sdaDriveLow),
    .softReset  (softReset)
  );

  assign regAddr   = ptr;
  assign regWrData = rxByte;
  assign regWrEn   = cmd.wrStb;
  assign regRdEn   = cmd.rdStb;

  // R2: outside START/STOP handling, the drive only moves while SCL is low
  assert_sda_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDriveLow) && !$past(evt.start) && !$past(evt.stop)) |-> !sclLvl);

endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;

  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sdaDriveLow;
  logic [7:0] regAddr, regWrData, regRdData;
  logic       regWrEn, regRdEn, softReset;
  wire        sdaBus = sdaM & ~sdaDriveLow;

  always #2.5 clk = ~clk;

  i2c_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapIn(strap),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData),
    .softReset(softReset)
  );

  // register file model owned by the bench
  logic [7:0] mem [256];
  int wrCount = 0, rdCount = 0, softCount = 0, r2Viol = 0;
  int nChecks = 0, nFail = 0;
  logic finished = 1'b0;
  logic [6:0] dev = 7'h45;
  logic prevDrv = 1'b0, prevScl = 1'b1;

  function automatic logic [7:0] pat(input logic [7:0] a);
    return (a * 8'h1D) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] nextA(input logic [7:0] a);
    return (a >= 8'h60 && a <= 8'h63) ? a : a + 8'd1;
  endfunction

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (regWrEn) begin mem[regAddr] <= regWrData; wrCount <= wrCount + 1; end
    if (regRdEn) rdCount <= rdCount + 1;
    if (softReset) softCount <= softCount + 1;
    // R2 monitor: drive must not move across a high SCL period
    if (rstN && sclM && prevScl && (sdaDriveLow != prevDrv)) r2Viol <= r2Viol + 1;
    prevDrv <= sdaDriveLow;
    prevScl <= sclM;
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; tick(Q); sclM = 1'b1; tick(2 * Q); sclM = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    acked = ~sdaDriveLow;
    acked = acked ? 1'b0 : 1'b1;
    acked = sdaDriveLow;
    tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
      b[i] = sdaBus; tick(Q); sclM = 1'b0; tick(Q);
    end
    sdaM = ~ackIt; tick(Q); sclM = 1'b1; tick(2 * Q); sclM = 1'b0; tick(Q); sdaM = 1'b1;
  endtask

  task automatic writeBurst(input logic [7:0] p, input int n, input logic [7:0] base, input string tag);
    logic ack;
    busStart();
    sendByte({dev, 1'b0}, ack); checkEq({tag, " address ack"}, ack, 1);
    sendByte(p, ack);           checkEq({tag, " pointer ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(base + 8'(i), ack); checkEq({tag, " data ack R4"}, ack, 1);
    end
    busStop();
  endtask

  task automatic readSeq(input logic setPtr, input logic [7:0] startA, input int n, input string tag);
    logic ack;
    logic [7:0] got;
    logic [7:0] a;
    a = startA;
    if (setPtr) begin
      busStart();
      sendByte({dev, 1'b0}, ack);
      sendByte(startA, ack);
    end
    busStart();
    sendByte({dev, 1'b1}, ack); checkEq({tag, " read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, got);
      checkEq(tag, got, pat(a));
      a = nextA(a);
    end
    busStop();
  endtask

  initial begin
    logic ack;
    logic [7:0] got;
    int wr0;
    for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
    tick(4);
    rstN = 1'b1;
    tick(3);
    strap = 3'b000;  // R3: changes after release must not move the address
    tick(2);

    // reset state (R1)
    checkEq("R1 reset sdaDriveLow", sdaDriveLow, 0);
    checkEq("R1 reset regWrEn", regWrEn, 0);
    checkEq("R1 reset regRdEn", regRdEn, 0);
    checkEq("R1 reset softReset", softReset, 0);

    // R1: a full byte before any START is ignored
    sclM = 1'b0; tick(Q);
    sendByte({7'h45, 1'b0}, ack);
    checkEq("R1 no ack before START", ack, 0);
    sendByte(8'h10, ack);
    checkEq("R1 no ack on second byte before START", ack, 0);
    sclM = 1'b1; tick(Q);
    busStop();
    checkEq("R1 no strobes before START", wrCount + rdCount, 0);

    // R3/R9: sweep every 7-bit address with the write direction
    for (int a = 0; a < 128; a++) begin
      busStart();
      sendByte({7'(a), 1'b0}, ack);
      busStop();
      if (a == 0) checkEq("R9 general call ack", ack, 1);
      else        checkEq($sformatf("R3 address %0h ack", a), ack, (a == 'h45) ? 1 : 0);
    end
    checkEq("R3 sweep caused no strobes", wrCount + rdCount, 0);
    checkEq("R1 idle after sweep", sdaDriveLow, 0);

    // R9: general call with read direction is refused
    busStart(); sendByte(8'h01, ack); busStop();
    checkEq("R9 0x01 not acknowledged", ack, 0);

    // R7 reads with auto-increment, continuation, wrap and window
    readSeq(1'b1, 8'h20, 5, "R7 burst read 0x20");
    checkEq("R7 fetch count stops at NACK", rdCount, 5);
    readSeq(1'b0, 8'h25, 1, "R7 continued read R5 pointer advanced");
    readSeq(1'b1, 8'hFE, 3, "R5 read wrap");
    readSeq(1'b1, 8'h61, 3, "R6 read window hold");

    // R4/R5/R6 writes
    wr0 = wrCount;
    writeBurst(8'h10, 6, 8'hA0, "R4 burst");
    checkEq("R4 write strobe count", wrCount - wr0, 6);
    for (int i = 0; i < 6; i++)
      checkEq($sformatf("R4 mem[%0h]", 16 + i), mem[8'h10 + 8'(i)], 8'hA0 + 8'(i));
    checkEq("R4 mem beyond burst untouched", mem[8'h16], pat(8'h16));
    writeBurst(8'hFE, 4, 8'hC0, "R5 wrap");
    checkEq("R5 mem[FE]", mem[8'hFE], 8'hC0);
    checkEq("R5 mem[FF]", mem[8'hFF], 8'hC1);
    checkEq("R5 mem[00]", mem[8'h00], 8'hC2);
    checkEq("R5 mem[01]", mem[8'h01], 8'hC3);
    writeBurst(8'h5E, 5, 8'hD0, "R6 window");
    checkEq("R6 mem[5E]", mem[8'h5E], 8'hD0);
    checkEq("R6 mem[5F]", mem[8'h5F], 8'hD1);
    checkEq("R6 mem[60] last write", mem[8'h60], 8'hD4);
    checkEq("R6 mem[61] untouched", mem[8'h61], pat(8'h61));

    // R8: repeated START in the middle of a data byte
    wr0 = wrCount;
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h30, ack);
    sendByte(8'hE1, ack);
    sendBits(8'h77, 3);
    sclM = 1'b0; tick(Q);
    busStart();
    sendByte({dev, 1'b0}, ack); checkEq("R8 address after restart ack", ack, 1);
    sendByte(8'h40, ack);
    sendByte(8'hE2, ack);
    busStop();
    checkEq("R8 mem[30]", mem[8'h30], 8'hE1);
    checkEq("R8 mem[31] untouched by partial byte", mem[8'h31], pat(8'h31));
    checkEq("R8 mem[40]", mem[8'h40], 8'hE2);
    checkEq("R8 write count", wrCount - wr0, 2);

    // R11: re-latch without reset, pointer kept
    busStart(); sendByte({dev, 1'b0}, ack); sendByte(8'h20, ack); busStop();
    strap = 3'b010;
    busStart(); sendByte(8'h00, ack); checkEq("R11 gc ack", ack, 1);
    sendByte(8'h04, ack); checkEq("R11 0x04 ack", ack, 1);
    busStop();
    checkEq("R11 no soft reset", softCount, 0);
    busStart(); sendByte({7'h45, 1'b0}, ack); busStop();
    checkEq("R11 old address refused", ack, 0);
    dev = 7'h42;
    readSeq(1'b0, 8'h20, 1, "R11 pointer kept after 0x04");

    // R11: other command values ignored
    strap = 3'b000;
    busStart(); sendByte(8'h00, ack); sendByte(8'h33, ack); busStop();
    checkEq("R11 0x33 not acknowledged", ack, 0);
    busStart(); sendByte(8'h00, ack); sendByte(8'h00, ack); busStop();
    checkEq("R11 0x00 command not acknowledged", ack, 0);
    busStart(); sendByte({7'h42, 1'b0}, ack); busStop();
    checkEq("R11 address unchanged by ignored command", ack, 1);
    checkEq("R11 no soft reset from ignored command", softCount, 0);

    // R10: reset command re-latches and clears the pointer
    strap = 3'b111;
    busStart(); sendByte(8'h00, ack); sendByte(8'h06, ack); busStop();
    checkEq("R10 0x06 ack", ack, 1);
    checkEq("R10 one soft reset pulse", softCount, 1);
    dev = 7'h47;
    busStart(); sendByte({dev, 1'b1}, ack);
    checkEq("R10 new address ack", ack, 1);
    recvByte(1'b0, got); busStop();
    checkEq("R10 pointer cleared reads mem[00]", got, 8'hC2);
    busStart(); sendByte({7'h42, 1'b0}, ack); busStop();
    checkEq("R10 previous address refused", ack, 0);

    // R2: drive never moved while SCL was high
    checkEq("R2 drive changes during SCL high", r2Viol, 0);
    checkEq("R1 released at end", sdaDriveLow, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule